// File: doc/BRIEF.md
# CAN Nominal Bit Timing Generator

This block derives CAN bit timing from a system clock and one packed 32-bit timing word. A prescaler divides the clock into time quanta. A segment sequencer then steps each bit through a one-quantum synchronization segment, a first phase segment and a second phase segment. It marks the first clock of every bit and the sample point, which is the end of the first phase segment. At the sample point it captures the receive line as the bit value. The bit rate is the clock frequency divided by the prescaler divide times the quanta per bit (1 + TSEG1 + TSEG2). For example, word `0x000D400B` on a 24 MHz clock gives 12 clocks per quantum and 16 quanta per bit, which is 192 clocks per bit or 125 kbit/s.

The block watches the receive line for recessive-to-dominant transitions. While the frame logic reports an idle bus, such a transition hard-synchronizes the bit: the bit restarts in the sync segment and the prescaler restarts. During a frame, a transition causes at most one resynchronization per bit. Resynchronization uses a jump width of one quantum: it lengthens the first phase segment or shortens the second.

Top module: `can_bit_timer`

## Requirements
- R1: The timing word is decoded as follows. Bits 9:0 hold the prescaler divide minus one. Bits 19:16 hold TSEG1 minus one (1..16 quanta). Bits 22:20 hold TSEG2 minus one (1..8 quanta). All other bits have no effect on timing.
- R2: While running, `tq_en_o` is high for one clock in every (divide) clocks.
- R3: Each undisturbed bit lasts 1 + TSEG1 + TSEG2 quanta. `seg_o` reads 0 in the sync segment, 1 in phase segment 1 and 2 in phase segment 2. The sample point lies 1 + TSEG1 quanta after the bit start.
- R4: `bit_start_o` is high for exactly the first clock of each sync segment.
- R5: `sample_o` is high for exactly the first clock of phase segment 2. On that same edge, `rx_bit_o` takes the value of `rx_i`, where 1 is recessive and 0 is dominant.
- R6: The timing word is captured only while `init_i` is high. Word changes made while `init_i` is low have no effect. While `init_i` is high, `seg_o` stays 0, `tq_en_o` stays low and both strobes stay low.
- R7: A 1-to-0 transition of `rx_i` while `bus_idle_i` is high restarts the bit in the sync segment on the next clock, with `bit_start_o` high, and restarts the prescaler count.
- R8: During a frame, a 1-to-0 transition in phase segment 1 lengthens that segment by one quantum.
- R9: During a frame, a 1-to-0 transition in phase segment 2 shortens that segment by one quantum. If the transition falls in its last quantum, the bit ends at once and a new sync segment starts with the prescaler restarted.
- R10: At most one resynchronization is applied per bit. A transition during the sync segment has no effect on timing.
- R11: After reset, `seg_o` is 0, both strobes are low and `rx_bit_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Configuration mode: holds the timer and captures the timing word |
| cfg_word_i | input | 32 | Packed timing word |
| rx_i | input | 1 | Receive line, 1 recessive and 0 dominant |
| bus_idle_i | input | 1 | High while the bus is idle; selects hard synchronization |
| tq_en_o | output | 1 | One-clock time-quantum enable |
| seg_o | output | 2 | Current segment: 0 sync, 1 phase 1, 2 phase 2 |
| bit_start_o | output | 1 | First clock of each bit |
| sample_o | output | 1 | Sample strobe, first clock after phase segment 1 |
| rx_bit_o | output | 1 | Receive value captured at the sample point |

## Verification
A wrong quantum count or a missed segment change shows up in `seg_o` within one quantum. It also moves the next `bit_start_o` or `sample_o` pulse by at least one quantum. A stuck resynchronization flag changes a later bit's length, so the fault is visible by the next bit start at the latest. The bench runs a behavioural quantum-index model with random receive traffic, in frame and in idle, and compares every output on every clock. Directed cases then measure bit lengths after edges in each segment, after a second edge in the same bit, and in the last quantum of phase segment 2.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  localparam int BRP_W = 10;
  localparam int TS1_W = 4;
  localparam int TS2_W = 3;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PH1  = 2'd1,
    SEG_PH2  = 2'd2
  } seg_e;

  typedef struct packed {
    logic [BRP_W-1:0] brp;
    logic [TS1_W-1:0] ts1;
    logic [TS2_W-1:0] ts2;
  } bt_cfg_t;
endpackage

// File: rtl/can_bt_cfg.sv
module can_bt_cfg
  import can_bt_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int BRP_LSB = 0,
  parameter int TS1_LSB = 16,
  parameter int TS2_LSB = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic [WORD_W-1:0] word_i,
  output bt_cfg_t           cfg_o
);
  bt_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (init_i) begin
      cfg_q.brp <= word_i[BRP_LSB +: BRP_W];
      cfg_q.ts1 <= word_i[TS1_LSB +: TS1_W];
      cfg_q.ts2 <= word_i[TS2_LSB +: TS2_W];
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         restart_i,
  input  logic [W-1:0] div_m1_i,
  output logic         tq_o
);
  logic [W-1:0] cnt_q;

  assign tq_o = run_i & (cnt_q == div_m1_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i || restart_i || tq_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/can_bt_seg.sv
module can_bt_seg
  import can_bt_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    run_i,
  input  logic    tq_i,
  input  logic    fall_i,
  input  logic    idle_i,
  input  logic    rx_i,
  input  bt_cfg_t cfg_i,
  output logic    restart_o,
  output logic [1:0] seg_o,
  output logic    bit_start_o,
  output logic    sample_o,
  output logic    rx_bit_o
);
  localparam int Q_W = TS1_W + 1;

  seg_e           seg_q;
  logic [Q_W-1:0] q_q;
  logic           ext_q, sh_q, done_q;
  logic           bs_q, smp_q, bit_q;

  logic fall, hard, ph2_last, early, set_ext, set_sh;
  logic ext_eff, sh_eff, ph1_end, ph2_end;

  always_comb begin
    fall     = fall_i & run_i;
    hard     = fall & idle_i;
    ph2_last = (seg_q == SEG_PH2) && (q_q == Q_W'(cfg_i.ts2));
    // resync only during a frame, once per bit, never in sync
    early    = fall & ~idle_i & ~done_q & ph2_last;
    set_ext  = fall & ~idle_i & ~done_q & (seg_q == SEG_PH1);
    set_sh   = fall & ~idle_i & ~done_q & (seg_q == SEG_PH2) & ~ph2_last;
    ext_eff  = ext_q | set_ext;
    sh_eff   = sh_q | set_sh;
    ph1_end  = tq_i && (seg_q == SEG_PH1) && (q_q == Q_W'(cfg_i.ts1) + Q_W'(ext_eff));
    ph2_end  = tq_i && (seg_q == SEG_PH2) && (q_q + Q_W'(sh_eff) == Q_W'(cfg_i.ts2));
  end

  assign restart_o = hard | early;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q  <= SEG_SYNC;
      q_q    <= '0;
      ext_q  <= 1'b0;
      sh_q   <= 1'b0;
      done_q <= 1'b0;
      bs_q   <= 1'b0;
      smp_q  <= 1'b0;
      bit_q  <= 1'b1;
    end else if (!run_i) begin
      seg_q  <= SEG_SYNC;
      q_q    <= '0;
      ext_q  <= 1'b0;
      sh_q   <= 1'b0;
      done_q <= 1'b0;
      bs_q   <= 1'b0;
      smp_q  <= 1'b0;
    end else if (restart_o) begin
      seg_q  <= SEG_SYNC;
      q_q    <= '0;
      ext_q  <= 1'b0;
      sh_q   <= 1'b0;
      done_q <= 1'b1;
      bs_q   <= 1'b1;
      smp_q  <= 1'b0;
    end else begin
      bs_q   <= 1'b0;
      smp_q  <= 1'b0;
      ext_q  <= ext_eff;
      sh_q   <= sh_eff;
      done_q <= done_q | set_ext | set_sh;
      if (tq_i) begin
        unique case (seg_q)
          SEG_SYNC: begin
            seg_q <= SEG_PH1;
            q_q   <= '0;
          end
          SEG_PH1: begin
            if (ph1_end) begin
              seg_q <= SEG_PH2;
              q_q   <= '0;
              smp_q <= 1'b1;
              bit_q <= rx_i;
            end else begin
              q_q <= q_q + 1'b1;
            end
          end
          SEG_PH2: begin
            if (ph2_end) begin
              seg_q  <= SEG_SYNC;
              q_q    <= '0;
              ext_q  <= 1'b0;
              sh_q   <= 1'b0;
              done_q <= 1'b0;
              bs_q   <= 1'b1;
            end else begin
              q_q <= q_q + 1'b1;
            end
          end
          default: begin
            seg_q <= SEG_SYNC;
            q_q   <= '0;
          end
        endcase
      end
    end
  end

  assign seg_o       = seg_q;
  assign bit_start_o = bs_q;
  assign sample_o    = smp_q;
  assign rx_bit_o    = bit_q;
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import can_bt_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int BRP_LSB = 0,
  parameter int TS1_LSB = 16,
  parameter int TS2_LSB = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic [WORD_W-1:0] cfg_word_i,
  input  logic              rx_i,
  input  logic              bus_idle_i,
  output logic              tq_en_o,
  output logic [1:0]        seg_o,
  output logic              bit_start_o,
  output logic              sample_o,
  output logic              rx_bit_o
);
  bt_cfg_t cfg;
  logic    run, tq, restart, rx_prev_q, fall;

  assign run  = ~init_i;
  assign fall = rx_prev_q & ~rx_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_prev_q <= 1'b1;
    else         rx_prev_q <= rx_i;
  end

  can_bt_cfg #(
    .WORD_W (WORD_W),
    .BRP_LSB(BRP_LSB),
    .TS1_LSB(TS1_LSB),
    .TS2_LSB(TS2_LSB)
  ) u_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .init_i(init_i),
    .word_i(cfg_word_i),
    .cfg_o (cfg)
  );

  can_bt_prescaler #(.W(BRP_W)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .restart_i(restart),
    .div_m1_i (cfg.brp),
    .tq_o     (tq)
  );

  can_bt_seg u_seg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .tq_i       (tq),
    .fall_i     (fall),
    .idle_i     (bus_idle_i),
    .rx_i       (rx_i),
    .cfg_i      (cfg),
    .restart_o  (restart),
    .seg_o      (seg_o),
    .bit_start_o(bit_start_o),
    .sample_o   (sample_o),
    .rx_bit_o   (rx_bit_o)
  );

  assign tq_en_o = tq;
endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       init_i,
  input logic       rx_i,
  input logic       bus_idle_i,
  input logic       tq_en_o,
  input logic [1:0] seg_o,
  input logic       bit_start_o,
  input logic       sample_o
);
  logic rx_d, past_ok, rx_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_d    <= 1'b1;
      past_ok <= 1'b0;
    end else begin
      rx_d    <= rx_i;
      past_ok <= 1'b1;
    end
  end

  assign rx_fall = rx_d & ~rx_i;

  p_seg_legal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_o != 2'd3);

  p_ph1_exit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(seg_o) == 2'd1 && seg_o == 2'd0) |->
      ($past(rx_fall && bus_idle_i) || $past(init_i)));

  p_seg_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && seg_o != $past(seg_o)) |->
      ($past(tq_en_o) || $past(rx_fall) || $past(init_i)));

  p_bs_in_sync_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_start_o |-> seg_o == 2'd0);

  p_smp_in_ph2_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> seg_o == 2'd2);

  p_smp_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> !sample_o);

  p_init_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (seg_o == 2'd0 && !bit_start_o && !sample_o));
endmodule

bind can_bit_timer can_bit_timer_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .init_i     (init_i),
  .rx_i       (rx_i),
  .bus_idle_i (bus_idle_i),
  .tq_en_o    (tq_en_o),
  .seg_o      (seg_o),
  .bit_start_o(bit_start_o),
  .sample_o   (sample_o)
);

// File: tb/sim_can_bit_timer.sv
`timescale 1ns/100ps
module sim_can_bit_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        init;
  logic [31:0] word;
  logic        rx;
  logic        idle;
  logic        tq_en, bs, smp, rx_bit;
  logic [1:0]  seg;

  always #2.5 clk = ~clk;

  can_bit_timer u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .init_i     (init),
    .cfg_word_i (word),
    .rx_i       (rx),
    .bus_idle_i (idle),
    .tq_en_o    (tq_en),
    .seg_o      (seg),
    .bit_start_o(bs),
    .sample_o   (smp),
    .rx_bit_o   (rx_bit)
  );

  int    n_chk = 0, n_fail = 0, cyc = 0, last_bs = 0, bs_gap = 0, smp_off = 0;
  string cur_req = "R3";
  bit    done_flag = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d cycle=%0d", req, act, exp, cyc);
    end
  endtask

  // behavioural model: quantum index within the bit
  int m_brp, m_ts1, m_ts2, m_clk, m_tq, m_ext, m_sh, m_done;
  bit m_rxp, e_bs, e_smp, e_bit;

  function automatic int m_seg();
    if (m_tq == 0) return 0;
    if (m_tq <= m_ts1 + m_ext) return 1;
    return 2;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    bit fe, tq; int sg, blen;
    if (!rst_n) begin
      m_brp = 0; m_ts1 = 1; m_ts2 = 1; m_clk = 0; m_tq = 0;
      m_ext = 0; m_sh = 0; m_done = 0; m_rxp = 1; e_bs = 0; e_smp = 0; e_bit = 1;
    end else begin
      fe = m_rxp && !rx; m_rxp = rx; e_bs = 0; e_smp = 0;
      if (init) begin
        m_brp = int'(word[9:0]); m_ts1 = int'(word[19:16]) + 1; m_ts2 = int'(word[22:20]) + 1;
        m_clk = 0; m_tq = 0; m_ext = 0; m_sh = 0; m_done = 0;
      end else begin
        sg   = m_seg();
        blen = 1 + m_ts1 + m_ext + m_ts2 - m_sh;
        tq   = (m_clk == m_brp);
        if ((fe && idle) || (fe && !idle && m_done == 0 && sg == 2 && m_tq == blen - 1)) begin
          m_clk = 0; m_tq = 0; m_ext = 0; m_sh = 0; m_done = 1; e_bs = 1;
        end else begin
          if (fe && !idle && m_done == 0 && sg == 1) begin m_ext = 1; m_done = 1; end
          else if (fe && !idle && m_done == 0 && sg == 2) begin m_sh = 1; m_done = 1; end
          if (tq) begin
            if (m_tq == m_ts1 + m_ext) begin e_smp = 1; e_bit = rx; end
            m_tq++;
            if (m_tq == 1 + m_ts1 + m_ext + m_ts2 - m_sh) begin
              m_tq = 0; m_ext = 0; m_sh = 0; m_done = 0; e_bs = 1;
            end
          end
          m_clk = tq ? 0 : m_clk + 1;
        end
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      cyc++;
      chk(seg == 2'(m_seg()), cur_req, seg, m_seg());
      chk(bs == e_bs, "R4", bs, e_bs);
      chk(smp == e_smp, "R5", smp, e_smp);
      chk(rx_bit == e_bit, "R5", rx_bit, e_bit);
      chk(tq_en == (!init && m_clk == m_brp), "R2", tq_en, (!init && m_clk == m_brp));
      if (bs) begin bs_gap = cyc - last_bs; last_bs = cyc; end
      if (smp) smp_off = cyc - last_bs;
    end
  end

  task automatic do_init(input logic [31:0] w);
    @(negedge clk); #1 init = 1'b1; word = w;
    repeat (2) @(negedge clk);
    #1 init = 1'b0;
  endtask

  task automatic wait_bs();
    do @(negedge clk); while (!bs);
    #1;
  endtask

  task automatic run_rand(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[3:0] == 4'd0) rx = ~rx;
    end
  endtask

  task automatic finish_run();
    done_flag = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R4 watchdog act=0 exp=1 cycle=%0d", cyc);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; init = 1'b1; word = '0; rx = 1'b1; idle = 1'b0;
    repeat (3) @(negedge clk);
    chk(seg == 2'd0, "R11", seg, 0);
    chk(bs == 1'b0, "R11", bs, 0);
    chk(smp == 1'b0, "R11", smp, 0);
    chk(rx_bit == 1'b1, "R11", rx_bit, 1);
    #1 rst_n = 1'b1;

    // R1: fields with junk in unused bits; 16 quanta x 12 clocks
    cur_req = "R1";
    do_init(32'hFF8DFC0B);
    wait_bs(); wait_bs();
    chk(bs_gap == 192, "R1", bs_gap, 192);
    chk(smp_off == 180, "R3", smp_off, 180);

    // R6: word change while running is ignored
    cur_req = "R6";
    word = 32'h0000_0000;
    wait_bs(); wait_bs();
    chk(bs_gap == 192, "R6", bs_gap, 192);

    cur_req = "R8 R9 R10";
    do_init(32'h0034_0003);
    run_rand(4000);
    cur_req = "R7";
    idle = 1'b1;
    run_rand(2000);
    idle = 1'b0;
    cur_req = "R9";
    do_init(32'h0000_0000);
    run_rand(3000);

    // R8: edge in first phase-1 quantum, bit 9 -> 10 clocks
    cur_req = "R8";
    rx = 1'b1;
    do_init(32'h0033_0000);
    wait_bs(); wait_bs();
    @(negedge clk); #1 rx = 1'b0;
    wait_bs();
    chk(bs_gap == 10, "R8", bs_gap, 10);

    // R9: edge in first phase-2 quantum, bit 9 -> 8 clocks
    cur_req = "R9";
    rx = 1'b1;
    repeat (5) @(negedge clk);
    chk(seg == 2'd2, "R9", seg, 2);
    #1 rx = 1'b0;
    wait_bs();
    chk(bs_gap == 8, "R9", bs_gap, 8);

    // R10: second edge in the same bit has no effect
    cur_req = "R10";
    rx = 1'b1;
    @(negedge clk); #1 rx = 1'b0;
    @(negedge clk); #1 rx = 1'b1;
    repeat (4) @(negedge clk);
    chk(seg == 2'd2, "R10", seg, 2);
    #1 rx = 1'b0;
    wait_bs();
    chk(bs_gap == 10, "R10", bs_gap, 10);
    rx = 1'b1;
    wait_bs();
    rx = 1'b0;
    wait_bs();
    chk(bs_gap == 9, "R10", bs_gap, 9);

    // R9: edge in the last phase-2 quantum ends the bit at once
    cur_req = "R9";
    rx = 1'b1;
    do_init(32'h0003_0003);
    wait_bs(); wait_bs();
    repeat (20) @(negedge clk);
    chk(seg == 2'd2, "R9", seg, 2);
    #1 rx = 1'b0;
    wait_bs();
    chk(bs_gap == 21, "R9", bs_gap, 21);

    // R7: hard sync in phase 1 while idle
    cur_req = "R7";
    rx = 1'b1; idle = 1'b1;
    do_init(32'h0033_0003);
    wait_bs();
    repeat (6) @(negedge clk);
    #1 rx = 1'b0;
    @(negedge clk);
    chk(bs == 1'b1, "R7", bs, 1);
    chk(seg == 2'd0, "R7", seg, 0);
    repeat (3) @(negedge clk);
    chk(tq_en == 1'b1, "R7", tq_en, 1);

    // R6: init holds the timer quiet
    cur_req = "R6";
    @(negedge clk); #1 init = 1'b1;
    repeat (3) @(negedge clk);
    chk(tq_en == 1'b0, "R6", tq_en, 0);
    chk(seg == 2'd0, "R6", seg, 0);
    #1 init = 1'b0;
    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule